// File: doc/BRIEF.md
# Comparator Event and Fault Controller

This block is the digital back end of an analog comparator. The comparator's raw output arrives as a single asynchronous bit. The block can invert that bit, then passes it through a flop synchroniser. It watches the synchronised level for a chosen kind of transition and records each match in a sticky event flag. Reading the status word clears that flag.

The flag drives an interrupt line through a mask bit. A separate fault line can follow either the sticky flag or the live synchronised level, and it can also be forced low. Software reaches the block through a simple 32-bit register port with a write strobe, a read strobe, a byte address and a combinational read path.

The input-select and analog-trim fields are only stored and driven out to the analog macro. A key-guarded protection bit can freeze the configuration registers. A control-register write performs a software reset of the block.

Top module: `cmp_evt_ctrl`

## Requirements
- R1: After reset every register reads 0, irq is 0 and fault is 0.
- R2: The mode word at offset 0x04 keeps only the bits in 0x7777 and reads them back. Its fields are: negative-input select at bits 2:0, positive-input select at bits 6:4, enable at bit 8, edge type at bits 10:9, invert at bit 12, fault-source select at bit 13 and fault enable at bit 14. The two select fields and the enable drive output pins.
- R3: An edge is judged between consecutive synchronised samples. Edge type 0 matches rising edges, 1 matches falling edges, 2 matches either and 3 matches none. No edge is recorded while enable is 0. The flag is visible three clock edges after the raw input changes.
- R4: With invert set, the raw input is complemented before synchronisation, so edge matching and the level in status bit 1 both use the complemented value.
- R5: At offset 0x30, status bit 0 is the event flag and bit 1 is the synchronised level. A read clears the flag. If an edge matches in the same cycle as the read, the flag stays set.
- R6: A write with bit 0 set to offset 0x24 sets the mask bit, and the same write to offset 0x28 clears it. The mask bit reads back at bit 0 of offset 0x2C. irq equals the flag ANDed with the mask.
- R7: With fault enable at 0, fault is 0. With fault enable at 1, fault follows the flag when fault-source is 0 and the synchronised level when fault-source is 1.
- R8: The analog-control word at offset 0x94 keeps bits 2:0, reads them back and drives them on ana_ctl.
- R9: At offset 0xE4, the protection enable is bit 0 and the key is bits 31:8. A write changes the enable only when the key equals 0x414343. The key field reads back as 0.
- R10: While protection is on, writes to 0x04 and 0x94 are ignored and set bit 0 of offset 0xE8. A read of 0xE8 clears that bit.
- R11: Writing 1 to bit 0 of offset 0x00 clears the mode word, the mask, the event flag, the analog-control word and the synchroniser. The protection state is left as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | 1 | Raw comparator output, asynchronous |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; clear-on-read side effects act on this edge |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| minus_sel | output | 3 | Negative-input select to the analog macro |
| plus_sel | output | 3 | Positive-input select to the analog macro |
| cmp_enable | output | 1 | Comparator enable |
| ana_ctl | output | 3 | Current and hysteresis trim |
| irq | output | 1 | Masked event interrupt |
| fault | output | 1 | Fault output |

## Verification
The edge detector is driven with a random walk of held input levels. Each step uses a random edge type, invert setting, enable, mask and fault configuration. The bench's own model tells rising, falling, either-edge and reserved matching apart, and it separates inverted from direct input. Directed cases cover an edge that lands in the same cycle as a status read, protected writes, wrong and right keys, and a software reset taken with protection on. Each of these shows whether a flag or register was kept or cleared.

// File: rtl/cev_pkg.sv
package cev_pkg;
  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_MODE = 8'h04;
  localparam logic [7:0] OFF_IEN  = 8'h24;
  localparam logic [7:0] OFF_IDIS = 8'h28;
  localparam logic [7:0] OFF_IMSK = 8'h2C;
  localparam logic [7:0] OFF_STAT = 8'h30;
  localparam logic [7:0] OFF_ANA  = 8'h94;
  localparam logic [7:0] OFF_PROT = 8'hE4;
  localparam logic [7:0] OFF_VIOL = 8'hE8;

  localparam int          MODE_W    = 15;
  localparam logic [14:0] MODE_KEEP = 15'h7777;
  localparam int          ANA_W     = 3;
  localparam logic [23:0] PROT_KEY  = 24'h414343;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2,
    EDGE_NONE = 2'd3
  } edge_sel_e;
endpackage

// File: rtl/cev_sync.sv
module cev_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q, chain_nxt;

  always_comb begin
    if (clr) chain_nxt = '0;
    else     chain_nxt = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_nxt;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cev_edge.sv
module cev_edge
  import cev_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      lvl,
  input  logic      enable,
  input  edge_sel_e edge_sel,
  output logic      hit
);
  logic prev_q, prev_nxt;
  logic rise, fall;

  assign prev_nxt = clr ? 1'b0 : lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_nxt;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

  always_comb begin
    hit = 1'b0;
    if (enable && !clr) begin
      unique case (edge_sel)
        EDGE_RISE: hit = rise;
        EDGE_FALL: hit = fall;
        EDGE_BOTH: hit = rise | fall;
        default:   hit = 1'b0;
      endcase
    end
  end

  // R3: disabled comparator records nothing
  a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !hit);
endmodule

// File: rtl/cev_regs.sv
module cev_regs
  import cev_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              edge_hit,
  input  logic              sync_lvl,
  output logic [MODE_W-1:0] mode_q,
  output logic [ANA_W-1:0]  ana_q,
  output logic              mask_q,
  output logic              flag_q,
  output logic              swrst
);
  logic [MODE_W-1:0] mode_nxt;
  logic [ANA_W-1:0]  ana_nxt;
  logic mask_nxt, flag_nxt, prot_q, prot_nxt, viol_q, viol_nxt;
  logic wr_mode, wr_ana, wr_prot, rd_stat, rd_viol, key_ok;

  assign swrst   = wr_en && (addr == ADDR_W'(OFF_CTRL)) && wdata[0];
  assign wr_mode = wr_en && (addr == ADDR_W'(OFF_MODE));
  assign wr_ana  = wr_en && (addr == ADDR_W'(OFF_ANA));
  assign wr_prot = wr_en && (addr == ADDR_W'(OFF_PROT));
  assign rd_stat = rd_en && (addr == ADDR_W'(OFF_STAT));
  assign rd_viol = rd_en && (addr == ADDR_W'(OFF_VIOL));
  assign key_ok  = (wdata[31:8] == PROT_KEY);

  always_comb begin
    mode_nxt = mode_q;
    ana_nxt  = ana_q;
    mask_nxt = mask_q;
    flag_nxt = flag_q;
    prot_nxt = prot_q;
    viol_nxt = viol_q;
    if (swrst) begin
      mode_nxt = '0;
      ana_nxt  = '0;
      mask_nxt = 1'b0;
      flag_nxt = 1'b0;
    end else begin
      if (wr_mode && !prot_q) mode_nxt = wdata[MODE_W-1:0] & MODE_KEEP;
      if (wr_ana && !prot_q)  ana_nxt  = wdata[ANA_W-1:0];
      if (wr_en && addr == ADDR_W'(OFF_IEN) && wdata[0])  mask_nxt = 1'b1;
      if (wr_en && addr == ADDR_W'(OFF_IDIS) && wdata[0]) mask_nxt = 1'b0;
      if (edge_hit)     flag_nxt = 1'b1;
      else if (rd_stat) flag_nxt = 1'b0;
    end
    if (wr_prot && key_ok) prot_nxt = wdata[0];
    if ((wr_mode || wr_ana) && prot_q) viol_nxt = 1'b1;
    else if (rd_viol)                  viol_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ana_q  <= '0;
      mask_q <= 1'b0;
      flag_q <= 1'b0;
      prot_q <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      mode_q <= mode_nxt;
      ana_q  <= ana_nxt;
      mask_q <= mask_nxt;
      flag_q <= flag_nxt;
      prot_q <= prot_nxt;
      viol_q <= viol_nxt;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_W'(OFF_MODE): rdata[MODE_W-1:0] = mode_q;
      ADDR_W'(OFF_IMSK): rdata[0]          = mask_q;
      ADDR_W'(OFF_STAT): rdata[1:0]        = {sync_lvl, flag_q};
      ADDR_W'(OFF_ANA):  rdata[ANA_W-1:0]  = ana_q;
      ADDR_W'(OFF_PROT): rdata[0]          = prot_q;
      ADDR_W'(OFF_VIOL): rdata[0]          = viol_q;
      default:           rdata             = '0;
    endcase
  end

  a_r3_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit && !swrst) |=> flag_q);
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !edge_hit) |=> !flag_q);
  a_r9_bad_key_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_prot && !key_ok) |=> $stable(prot_q));
  a_r10_locked_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && prot_q) |=> ($stable(mode_q) && viol_q));
endmodule

// File: rtl/cmp_evt_ctrl.sv
module cmp_evt_ctrl
  import cev_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_raw,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [2:0]        minus_sel,
  output logic [2:0]        plus_sel,
  output logic              cmp_enable,
  output logic [2:0]        ana_ctl,
  output logic              irq,
  output logic              fault
);
  logic [MODE_W-1:0] mode_q;
  logic [ANA_W-1:0]  ana_q;
  logic mask_q, flag_q, swrst, sync_lvl, edge_hit;
  logic inv, fault_src, fault_en;
  edge_sel_e edge_sel;

  assign minus_sel  = mode_q[2:0];
  assign plus_sel   = mode_q[6:4];
  assign cmp_enable = mode_q[8];
  assign edge_sel   = edge_sel_e'(mode_q[10:9]);
  assign inv        = mode_q[12];
  assign fault_src  = mode_q[13];
  assign fault_en   = mode_q[14];
  assign ana_ctl    = ana_q;

  cev_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .edge_hit(edge_hit), .sync_lvl(sync_lvl),
    .mode_q(mode_q), .ana_q(ana_q), .mask_q(mask_q), .flag_q(flag_q),
    .swrst(swrst)
  );

  cev_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .clr(swrst), .d(cmp_raw ^ inv), .q(sync_lvl)
  );

  cev_edge u_edge (
    .clk(clk), .rst_n(rst_n), .clr(swrst), .lvl(sync_lvl),
    .enable(cmp_enable), .edge_sel(edge_sel), .hit(edge_hit)
  );

  assign irq   = flag_q & mask_q;
  assign fault = fault_en & (fault_src ? sync_lvl : flag_q);

  a_r7_fault_from_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !fault_src) |-> flag_q);
endmodule

// File: tb/tb_cmp_evt_ctrl.sv
module tb_cmp_evt_ctrl;
  logic clk = 1'b0;
  logic rst_n, cmp_raw, wr_en, rd_en;
  logic [7:0] addr;
  logic [31:0] wdata, rdata;
  logic [2:0] minus_sel, plus_sel, ana_ctl;
  logic cmp_enable, irq, fault;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  cmp_evt_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .minus_sel(minus_sel),
    .plus_sel(plus_sel), .cmp_enable(cmp_enable), .ana_ctl(ana_ctl),
    .irq(irq), .fault(fault)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic logic model_edge(input int es, input logic o, input logic n);
    case (es)
      0: return !o && n;
      1: return o && !n;
      2: return o != n;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] mode_word(input int es, input logic en, input logic inv,
                                            input logic src, input logic fe);
    return {17'b0, fe, src, inv, 1'b0, 2'(es), en, 8'h00};
  endfunction

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic lvl, nlvl, exp_flag, msk;
    int es;
    logic en, inv, src, fe;
    rst_n = 1'b0; cmp_raw = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    void'($urandom(32'd17));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h04, d); chk("R1 mode", d, 0);
    rd(8'h2C, d); chk("R1 mask", d, 0);
    rd(8'h30, d); chk("R1 status", d, 0);
    rd(8'hE4, d); chk("R1 prot", d, 0);
    chk("R1 irq/fault", {irq, fault}, 0);

    // R2 mode mask and output pins
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R2 readback", d, 32'h7777);
    chk("R2 pins", {minus_sel, plus_sel, cmp_enable}, 7'h7F);
    // R8 analog word
    wr(8'h94, 32'hFFFF_FFFF);
    rd(8'h94, d); chk("R8 readback", d, 32'h7);
    chk("R8 pins", ana_ctl, 3'h7);

    // R3/R4/R6/R7 random walk
    lvl = 1'b0;
    for (int i = 0; i < 60; i++) begin
      es = int'($urandom % 4);
      en = ($urandom % 4) != 0;
      inv = $urandom % 2;
      src = $urandom % 2;
      fe = $urandom % 2;
      msk = $urandom % 2;
      wr(8'h04, mode_word(es, en, inv, src, fe));
      wr(msk ? 8'h24 : 8'h28, 32'h1);
      settle();
      rd(8'h30, d);
      lvl = cmp_raw ^ inv;
      nlvl = $urandom % 2;
      @(negedge clk); cmp_raw = nlvl ^ inv;
      settle();
      exp_flag = en && model_edge(es, lvl, nlvl);
      chk("R6 irq", irq, exp_flag & msk);
      chk("R7 fault", fault, fe & (src ? nlvl : exp_flag));
      rd(8'h30, d);
      chk("R3 R4 flag/level", d, {30'b0, nlvl, exp_flag});
      rd(8'h30, d); chk("R5 cleared", d[0], 1'b0);
    end

    // R4 directed: inverted rising raw is a falling processed edge
    wr(8'h04, mode_word(0, 1, 1, 0, 0));
    @(negedge clk); cmp_raw = 1'b0; settle(); rd(8'h30, d);
    @(negedge clk); cmp_raw = 1'b1; settle();
    rd(8'h30, d); chk("R4 inverted rise no flag", d, 32'h0);

    // R5 edge in the same cycle as status read keeps the flag
    wr(8'h04, mode_word(0, 1, 0, 0, 0));
    @(negedge clk); cmp_raw = 1'b0; settle(); rd(8'h30, d);
    @(negedge clk); cmp_raw = 1'b1;
    @(negedge clk);
    rd(8'h30, d);
    rd(8'h30, d); chk("R5 same-cycle kept", d[0], 1'b1);
    rd(8'h30, d); chk("R5 then cleared", d[0], 1'b0);

    // R7 fault disabled with flag set
    wr(8'h04, mode_word(1, 1, 0, 0, 0));
    @(negedge clk); cmp_raw = 1'b0; settle();
    chk("R7 fault off", fault, 1'b0);
    wr(8'h04, mode_word(1, 1, 0, 0, 1));
    chk("R7 fault on flag", fault, 1'b1);

    // R9 key check
    wr(8'hE4, 32'h1234_5601);
    rd(8'hE4, d); chk("R9 wrong key", d, 0);
    wr(8'hE4, 32'h4143_4301);
    rd(8'hE4, d); chk("R9 right key, key reads 0", d, 32'h1);

    // R10 protected writes
    wr(8'h04, 32'h0);
    rd(8'h04, d); chk("R10 mode held", d, mode_word(1, 1, 0, 0, 1));
    wr(8'h94, 32'h2);
    rd(8'h94, d); chk("R10 ana held", d, 32'h7);
    rd(8'hE8, d); chk("R10 violation", d, 32'h1);
    rd(8'hE8, d); chk("R10 violation cleared", d, 32'h0);

    // R11 software reset with protection on
    wr(8'h24, 32'h1);
    wr(8'h00, 32'h1);
    rd(8'h04, d); chk("R11 mode", d, 0);
    rd(8'h2C, d); chk("R11 mask", d, 0);
    rd(8'h30, d); chk("R11 flag", d[0], 1'b0);
    rd(8'h94, d); chk("R11 ana", d, 0);
    rd(8'hE4, d); chk("R11 prot kept", d, 32'h1);
    wr(8'hE4, 32'h4143_4300);
    rd(8'hE4, d); chk("R9 unlock", d, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule